// File: doc/BRIEF.md
# Binary FSK Modulator with Dual Tone Oscillators

This block converts a serial bit stream into a sampled binary frequency-shift-keyed waveform. Two phase-accumulator oscillators run on every clock at frequencies set by two tuning words. A selector forwards the samples of one oscillator or the other according to the bit currently being sent. Each bit is held for a fixed number of output samples.

The upstream packet source offers one bit at a time on a valid/request handshake. The block stays silent after reset and ignores bits until it sees one flagged as the start of a packet. From that point it emits a contiguous run of samples. If the source has no bit ready when the block asks for one, the block goes silent again and waits for the next start-of-packet bit. The samples are not shaped or filtered.

Top module: `fsk_modulator`

## Requirements
- R1: Each oscillator has a 24-bit phase accumulator that is 0 after reset and grows by its own tuning word (modulo 2^24) on every clock, whether the output is enabled or not. The phase of each tone therefore carries on across bit changes.
- R2: A valid output sample equals round(2047 * sin(2*pi*a/256)), with a tolerance of 1 LSB. Here a is bits 23:16 of the selected accumulator in the cycle before the sample appears. The sample is a 12-bit two's-complement value.
- R3: Bit value 0 selects the oscillator driven by `tune0_in`, and bit value 1 selects the one driven by `tune1_in`.
- R4: Each accepted bit produces exactly 64 consecutive valid samples. The next accepted bit follows with no gap.
- R5: After reset, `sample_valid_o` is 0, `sample_o` is 0 and `bit_req_o` is 1.
- R6: While idle, a bit is accepted only if `sof_in` is high. The first valid sample then appears one cycle after the accepting clock edge. While idle, bits offered with `sof_in` low are ignored, and the output stays invalid.
- R7: `bit_req_o` is high whenever the block is idle. While the block is active, it is high only in the cycle of the 64th sample of the current bit. A bit is taken at a rising edge where both `bit_req_o` and `bit_valid_in` are high.
- R8: If `bit_valid_in` is low at the edge that ends a bit, the block becomes idle. `sample_valid_o` falls one cycle later, and a new `sof_in` bit is needed to restart.
- R9: Whenever `sample_valid_o` is 0, `sample_o` is 0.
- R10: While the block is active, `sof_in` has no effect. A flagged bit is sent as an ordinary data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Data bit offered by the source |
| bit_valid_in | input | 1 | `bit_in` is valid |
| sof_in | input | 1 | Offered bit is the first of a packet |
| tune0_in | input | 24 | Phase increment of the tone used for bit 0 |
| tune1_in | input | 24 | Phase increment of the tone used for bit 1 |
| bit_req_o | output | 1 | Block will take a bit at the next edge |
| sample_o | output | 12 | Signed output sample |
| sample_valid_o | output | 1 | `sample_o` carries a tone sample |

## Verification
A bit taken at edge E sets the selected tone at E, and its first sample is registered at E+1. A return to idle at E likewise clears `sample_valid_o` at E+1. `bit_req_o` is combinational from the state, so it reflects edge E straight away. The bench keeps a cycle-accurate expectation model that updates on the same rising edges from the same input values. It compares the outputs against that model on the falling edge, when every register of the block has settled. Directed checks count samples per packet and look at the idle, underflow and reset cases.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    typedef enum logic {
        TONE_ZERO = 1'b0,
        TONE_ONE  = 1'b1
    } tone_e;

    localparam real FSK_PI = 3.14159265358979;

    // Rounded sine code for table entry idx of depth entries, peak amp.
    function automatic int sine_code(int idx, int depth, int amp);
        real ang;
        ang = 2.0 * FSK_PI * real'(idx) / real'(depth);
        return $rtoi($floor(real'(amp) * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/fsk_nco.sv
module fsk_nco #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_in,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [PHASE_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q + tune_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign addr_o = acc_q[PHASE_W-1 -: ADDR_W];

    // R1
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> acc_q == PHASE_W'($past(acc_q) + $past(tune_in)));

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic [ADDR_W-1:0]        addr_in,
    output logic signed [DATA_W-1:0] data_o
);
    import fsk_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (DATA_W - 1)) - 1;

    logic signed [DATA_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int CODE = sine_code(i, DEPTH, AMP);
        assign rom[i] = DATA_W'(CODE);
    end

    assign data_o = rom[addr_in];

endmodule

// File: rtl/fsk_bit_ctrl.sv
module fsk_bit_ctrl #(
    parameter int SPB = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_in,
    input  logic            bit_valid_in,
    input  logic            sof_in,
    output logic            bit_req_o,
    output logic            active_o,
    output fsk_pkg::tone_e  tone_o
);
    import fsk_pkg::*;

    localparam int CNT_W = (SPB > 1) ? $clog2(SPB) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SPB - 1);

    typedef struct packed {
        logic             en;
        tone_e            tone;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    assign bit_req_o = !st_q.en || (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!st_q.en) begin
            if (bit_valid_in && sof_in) begin
                st_d.en   = 1'b1;
                st_d.tone = tone_e'(bit_in);
                st_d.cnt  = '0;
            end
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            if (bit_valid_in) st_d.tone = tone_e'(bit_in);
            else              st_d.en   = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, tone: TONE_ZERO, cnt: '0};
        else        st_q <= st_d;
    end

    assign active_o = st_q.en;
    assign tone_o   = st_q.tone;

    // R6
    sof_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && bit_valid_in && sof_in) |=> (st_q.en && st_q.cnt == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !(bit_valid_in && sof_in)) |=> !st_q.en);

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.cnt != LAST) |=> (st_q.en && $stable(st_q.tone)));

    // R8
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && bit_req_o && !bit_valid_in) |=> !st_q.en);

endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 8,
    parameter int SAMP_W  = 12,
    parameter int SPB     = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_in,
    input  logic                     bit_valid_in,
    input  logic                     sof_in,
    input  logic [PHASE_W-1:0]       tune0_in,
    input  logic [PHASE_W-1:0]       tune1_in,
    output logic                     bit_req_o,
    output logic signed [SAMP_W-1:0] sample_o,
    output logic                     sample_valid_o
);
    import fsk_pkg::*;

    localparam int N_TONES = 2;

    typedef struct packed {
        logic                     vld;
        logic signed [SAMP_W-1:0] smp;
    } out_t;

    logic [PHASE_W-1:0]       tune_w [N_TONES];
    logic [ADDR_W-1:0]        addr_w [N_TONES];
    logic [ADDR_W-1:0]        sel_addr;
    logic signed [SAMP_W-1:0] rom_data;
    logic                     active;
    tone_e                    tone;
    out_t                     out_d, out_q;

    assign tune_w[0] = tune0_in;
    assign tune_w[1] = tune1_in;

    for (genvar g = 0; g < N_TONES; g++) begin : g_osc
        fsk_nco #(
            .PHASE_W (PHASE_W),
            .ADDR_W  (ADDR_W)
        ) nco_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tune_in (tune_w[g]),
            .addr_o  (addr_w[g])
        );
    end

    fsk_bit_ctrl #(
        .SPB (SPB)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid_in (bit_valid_in),
        .sof_in       (sof_in),
        .bit_req_o    (bit_req_o),
        .active_o     (active),
        .tone_o       (tone)
    );

    assign sel_addr = (tone == TONE_ONE) ? addr_w[1] : addr_w[0];

    fsk_sine_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (SAMP_W)
    ) rom_i (
        .addr_in (sel_addr),
        .data_o  (rom_data)
    );

    always_comb begin
        out_d.vld = active;
        out_d.smp = active ? rom_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sample_o       = out_q.smp;
    assign sample_valid_o = out_q.vld;

    // R6
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> sample_valid_o);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sample_valid_o);

endmodule

// File: tb/fsk_modulator_tb_top.sv
module fsk_modulator_tb_top;

    localparam int  SPB    = 64;
    localparam int  NVEC   = 4;
    localparam real TB_PI  = 3.14159265358979;

    localparam logic [23:0] VEC_TW0 [NVEC] = '{24'h040000, 24'h012345, 24'h100000, 24'hFFFFFF};
    localparam logic [23:0] VEC_TW1 [NVEC] = '{24'h0A0000, 24'h0F0F0F, 24'h001000, 24'h7FFFFF};
    localparam logic [15:0] VEC_PAT [NVEC] = '{16'h00B2, 16'h005A, 16'h0005, 16'h0033};
    localparam logic [15:0] VEC_SOF [NVEC] = '{16'h0001, 16'h0009, 16'h0001, 16'h0001};
    localparam int          VEC_LEN [NVEC] = '{5, 8, 3, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0, bit_valid_in = 1'b0, sof_in = 1'b0;
    logic [23:0] tune0_in = '0, tune1_in = '0;
    logic bit_req_o, sample_valid_o;
    logic signed [11:0] sample_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit model_on = 1'b0;
    int vld_count = 0;

    always #2 clk = ~clk;

    fsk_modulator dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_in         (bit_in),
        .bit_valid_in   (bit_valid_in),
        .sof_in         (sof_in),
        .tune0_in       (tune0_in),
        .tune1_in       (tune1_in),
        .bit_req_o      (bit_req_o),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_sine(input logic [7:0] a);
        return $rtoi($floor(2047.0 * $sin(2.0 * TB_PI * real'(a) / 256.0) + 0.5));
    endfunction

    // Expectation model written from the requirements
    logic [23:0] m_acc0, m_acc1;
    logic        m_en, m_bit, m_vld;
    int          m_cnt;
    int          m_smp;
    logic        m_req;

    assign m_req = !m_en || (m_cnt == SPB - 1);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc0 <= '0; m_acc1 <= '0;
            m_en <= 1'b0; m_bit <= 1'b0; m_cnt <= 0;
            m_vld <= 1'b0; m_smp <= 0;
        end else begin
            m_acc0 <= m_acc0 + tune0_in;
            m_acc1 <= m_acc1 + tune1_in;
            m_vld  <= m_en;
            m_smp  <= m_en ? exp_sine(m_bit ? m_acc1[23:16] : m_acc0[23:16]) : 0;
            if (!m_en) begin
                if (bit_valid_in && sof_in) begin
                    m_en <= 1'b1; m_bit <= bit_in; m_cnt <= 0;
                end
            end else if (m_cnt == SPB - 1) begin
                m_cnt <= 0;
                if (bit_valid_in) m_bit <= bit_in;
                else              m_en  <= 1'b0;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            if (sample_valid_o) vld_count++;
            check(sample_valid_o == m_vld, "R4/R6/R8 sample_valid_o", int'(sample_valid_o), int'(m_vld));
            check(bit_req_o == m_req, "R7 bit_req_o", int'(bit_req_o), int'(m_req));
            if (m_vld)
                check((int'(sample_o) - m_smp <= 1) && (m_smp - int'(sample_o) <= 1),
                      "R1/R2/R3 sample_o", int'(sample_o), m_smp);
            else
                check(sample_o == 12'sd0, "R9 sample_o idle", int'(sample_o), 0);
        end
    end

    task automatic send_bit(input logic b, input logic sof);
        while (!bit_req_o) @(negedge clk);
        bit_in = b; sof_in = sof; bit_valid_in = 1'b1;
        @(negedge clk);
        bit_valid_in = 1'b0; sof_in = 1'b0; bit_in = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_en || m_vld) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        check(sample_valid_o == 1'b0, "R5 valid after reset", int'(sample_valid_o), 0);
        check(sample_o == 12'sd0, "R5 sample after reset", int'(sample_o), 0);
        check(bit_req_o == 1'b1, "R5 bit_req after reset", int'(bit_req_o), 1);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // Table of packets
        for (int v = 0; v < NVEC; v++) begin
            tune0_in = VEC_TW0[v];
            tune1_in = VEC_TW1[v];
            vld_count = 0;
            for (int k = 0; k < VEC_LEN[v]; k++)
                send_bit(VEC_PAT[v][k], VEC_SOF[v][k]);
            wait_idle();
            // R4, R10: samples per packet; mid-packet sof bits are plain data
            check(vld_count == SPB * VEC_LEN[v], "R4/R10 samples per packet", vld_count, SPB * VEC_LEN[v]);
        end

        // R6: bits without sof while idle are ignored
        vld_count = 0;
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check(vld_count == 0, "R6 idle bits ignored", vld_count, 0);
        check(sample_valid_o == 1'b0, "R6 idle stays invalid", int'(sample_valid_o), 0);

        // R6: start one cycle after accepting edge
        while (!bit_req_o) @(negedge clk);
        bit_in = 1'b1; sof_in = 1'b1; bit_valid_in = 1'b1;
        @(negedge clk);
        bit_valid_in = 1'b0; sof_in = 1'b0;
        check(sample_valid_o == 1'b0, "R6 no sample at accept edge", int'(sample_valid_o), 0);
        @(negedge clk);
        check(sample_valid_o == 1'b1, "R6 first sample next cycle", int'(sample_valid_o), 1);

        // R8: underflow after a single bit, then restart needs sof
        wait_idle();
        check(bit_req_o == 1'b1, "R8 idle after underflow", int'(bit_req_o), 1);
        vld_count = 0;
        send_bit(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(vld_count == 0, "R8 restart needs sof", vld_count, 0);

        // R5: reset while active
        send_bit(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        check(sample_valid_o == 1'b1, "R5 active before reset", int'(sample_valid_o), 1);
        rst_n = 1'b0;
        #1;
        check(sample_valid_o == 1'b0, "R5 valid in reset", int'(sample_valid_o), 0);
        check(bit_req_o == 1'b1, "R5 bit_req in reset", int'(bit_req_o), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sample_valid_o == 1'b0, "R5 idle after reset", int'(sample_valid_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule